// File: doc/BRIEF.md
# PCI interrupt line router

This block maps a small set of level-sensitive PCI interrupt request lines onto a bank of legacy ISA interrupt outputs. Each request line has its own byte-wide route register. A value below the number of ISA lines selects the ISA output with that number. A larger value switches the line off. Several request lines may select the same ISA output, and that output is then the OR of their levels.

Software reaches the route registers, and a handful of fixed-default configuration bytes, through a dword-addressed configuration port with per-byte enables. The block reports the current route of every request line on status pins. It also raises a one-cycle notification whenever a write lands on a route byte, so that downstream logic can refresh anything it derived from the routing.

Top module: `pirq_router`

## Requirements
- R1: After reset every route byte (offsets 0x60..0x63, byte 0x60+n for line n) holds 0x80, all ISA outputs are low, every route enable is clear, and the read data is zero.
- R2: The fixed configuration bytes reset to 0x04=0x07, 0x07=0x02, 0x4C=0x4D, 0x4E=0x03, 0x69=0x02 and 0x70=0x80. They are writable, and reads return the stored value in lane (offset mod 4) of the dword at (offset div 4).
- R3: A route byte value v in 0..15 sends that line's level to ISA output bit v.
- R4: A route byte value of 16 or more disables the line, so it drives no ISA output and its route enable reads 0.
- R5: Each ISA output is the OR of the levels of all enabled lines routed to it, for any number of sharers.
- R6: A write updates only the byte lanes whose enable bit (bit i for lane i) is set, and the other route bytes keep their values.
- R7: A write with at least one enabled lane on a route byte pulses route_chg high for exactly the cycle after the write. Writes that touch no route byte leave it low.
- R8: The ISA outputs are registered. A level change appears after the next clock edge, and a route write takes effect on the ISA outputs one edge after the route register changes.
- R9: route_en[n] shows whether line n is enabled, and route_irq[4n+3:4n] shows its low four route bits. Both change only after a write.
- R10: Reads of offsets with no implemented byte return zero in those lanes, and writes to them change nothing readable.
- R11: cfg_rdata is loaded on the edge that samples cfg_rd and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | CFG_AW (8) | Byte address; the low two bits are ignored |
| cfg_wdata | input | DATA_W (32) | Write data, lane i in bits 8i+7:8i |
| cfg_be | input | DATA_W/8 (4) | Per-lane write enables |
| cfg_rdata | output | DATA_W (32) | Registered read data |
| pirq_lvl | input | NUM_PIRQ (4) | Active-high request line levels |
| isa_irq | output | NUM_ISA (16) | Registered ISA interrupt outputs |
| route_chg | output | 1 | One-cycle pulse after a route byte write |
| route_en | output | NUM_PIRQ (4) | Per-line route enable |
| route_irq | output | NUM_PIRQ*4 (16) | Per-line ISA number, 4 bits each |

## Verification
The bench builds the block with its default parameters: four request lines, sixteen ISA outputs and a 32-bit port. At that size it is practical to sweep every line through route values 0 to 31, plus 0x80 and 0xFF, with single-lane byte enables. This covers each enabled ISA target, the boundary at 16 and the masking of neighbouring lanes. One hundred arithmetic mixes of routes and levels then exercise sharing of an output by several lines, and a dedicated sequence checks the one-edge lag between a route write and the ISA outputs.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

  localparam int FIXED_CNT = 6;

  // Offsets and reset values of the fixed-default configuration bytes
  localparam logic [7:0] FIXED_OFF [FIXED_CNT] = '{8'h04, 8'h07, 8'h4C, 8'h4E, 8'h69, 8'h70};
  localparam logic [7:0] FIXED_RST [FIXED_CNT] = '{8'h07, 8'h02, 8'h4D, 8'h03, 8'h02, 8'h80};

  // Route byte reset value: disabled
  localparam logic [7:0] ROUTE_RST = 8'h80;

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_router_pkg::*;
#(
  parameter int         NUM_PIRQ   = 4,
  parameter int         CFG_AW     = 8,
  parameter int         DATA_W     = 32,
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [CFG_AW-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   be,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_PIRQ*8-1:0] route_bytes,
  output logic                  route_wr
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int WORD_W = CFG_AW - LANE_W;

  logic [WORD_W-1:0] word_sel;
  logic [DATA_W-1:0] rd_route [NUM_PIRQ];
  logic [DATA_W-1:0] rd_fixed [FIXED_CNT];
  logic [NUM_PIRQ-1:0] route_hit;
  logic [DATA_W-1:0] rd_any;
  logic unused_lane_bits;

  assign word_sel         = addr[CFG_AW-1:LANE_W];
  assign unused_lane_bits = ^addr[LANE_W-1:0];

  // Route bytes, one per request line
  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
    localparam int OFF  = int'(ROUTE_BASE) + n;
    localparam int LANE = OFF % LANES;
    localparam int WORD = OFF / LANES;
    logic [7:0] val_q;
    logic       sel;

    assign sel          = (word_sel == WORD_W'(WORD));
    assign route_hit[n] = wr && sel && be[LANE];

    always_ff @(posedge clk) begin
      if (rst)               val_q <= ROUTE_RST;
      else if (route_hit[n]) val_q <= wdata[LANE*8 +: 8];
    end

    assign route_bytes[n*8 +: 8] = val_q;
    assign rd_route[n] = sel ? (DATA_W'(val_q) << (LANE*8)) : '0;
  end

  // Fixed-default bytes
  for (genvar f = 0; f < FIXED_CNT; f++) begin : g_fixed
    localparam int OFF  = int'(FIXED_OFF[f]);
    localparam int LANE = OFF % LANES;
    localparam int WORD = OFF / LANES;
    logic [7:0] val_q;
    logic       sel;

    assign sel = (word_sel == WORD_W'(WORD));

    always_ff @(posedge clk) begin
      if (rst)                   val_q <= FIXED_RST[f];
      else if (wr && sel && be[LANE]) val_q <= wdata[LANE*8 +: 8];
    end

    assign rd_fixed[f] = sel ? (DATA_W'(val_q) << (LANE*8)) : '0;
  end

  always_comb begin
    rd_any = '0;
    for (int n = 0; n < NUM_PIRQ; n++)  rd_any = rd_any | rd_route[n];
    for (int f = 0; f < FIXED_CNT; f++) rd_any = rd_any | rd_fixed[f];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      route_wr <= 1'b0;
    end else begin
      route_wr <= |route_hit;
      if (rd) rdata <= rd_any;
    end
  end

endmodule

// File: rtl/pirq_route_decode.sv
module pirq_route_decode #(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_ISA  = 16,
  parameter int ISA_W    = $clog2(NUM_ISA)
) (
  input  logic [NUM_PIRQ*8-1:0]     route_bytes,
  output logic [NUM_PIRQ-1:0]       en,
  output logic [NUM_PIRQ*ISA_W-1:0] num
);

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_dec
    logic [7:0] b;
    assign b                   = route_bytes[n*8 +: 8];
    assign en[n]               = (int'(b) < NUM_ISA);
    assign num[n*ISA_W +: ISA_W] = b[ISA_W-1:0];
  end

endmodule

// File: rtl/pirq_level_combine.sv
module pirq_level_combine #(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_ISA  = 16,
  parameter int ISA_W    = $clog2(NUM_ISA)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PIRQ-1:0]       lvl,
  input  logic [NUM_PIRQ-1:0]       en,
  input  logic [NUM_PIRQ*ISA_W-1:0] num,
  output logic [NUM_ISA-1:0]        isa_q
);

  logic [NUM_ISA-1:0] isa_d;

  always_comb begin
    isa_d = '0;
    for (int j = 0; j < NUM_ISA; j++) begin
      for (int n = 0; n < NUM_PIRQ; n++) begin
        if (en[n] && lvl[n] && (num[n*ISA_W +: ISA_W] == ISA_W'(j)))
          isa_d[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) isa_q <= '0;
    else     isa_q <= isa_d;
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int         NUM_PIRQ   = 4,
  parameter int         NUM_ISA    = 16,
  parameter int         CFG_AW     = 8,
  parameter int         DATA_W     = 32,
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic                       cfg_rd,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  input  logic [DATA_W/8-1:0]        cfg_be,
  output logic [DATA_W-1:0]          cfg_rdata,
  input  logic [NUM_PIRQ-1:0]        pirq_lvl,
  output logic [NUM_ISA-1:0]         isa_irq,
  output logic                       route_chg,
  output logic [NUM_PIRQ-1:0]        route_en,
  output logic [NUM_PIRQ*$clog2(NUM_ISA)-1:0] route_irq
);

  localparam int ISA_W = $clog2(NUM_ISA);

  logic [NUM_PIRQ*8-1:0] route_bytes;

  pirq_cfg_regs #(
    .NUM_PIRQ  (NUM_PIRQ),
    .CFG_AW    (CFG_AW),
    .DATA_W    (DATA_W),
    .ROUTE_BASE(ROUTE_BASE)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (cfg_wr),
    .rd         (cfg_rd),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .be         (cfg_be),
    .rdata      (cfg_rdata),
    .route_bytes(route_bytes),
    .route_wr   (route_chg)
  );

  pirq_route_decode #(
    .NUM_PIRQ(NUM_PIRQ),
    .NUM_ISA (NUM_ISA),
    .ISA_W   (ISA_W)
  ) u_dec (
    .route_bytes(route_bytes),
    .en         (route_en),
    .num        (route_irq)
  );

  pirq_level_combine #(
    .NUM_PIRQ(NUM_PIRQ),
    .NUM_ISA (NUM_ISA),
    .ISA_W   (ISA_W)
  ) u_comb (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pirq_lvl),
    .en   (route_en),
    .num  (route_irq),
    .isa_q(isa_irq)
  );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_ISA  = 16,
  parameter int DATA_W   = 32,
  parameter int IRQ_W    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_wr,
  input logic                cfg_rd,
  input logic [DATA_W-1:0]   cfg_rdata,
  input logic [NUM_PIRQ-1:0] pirq_lvl,
  input logic [NUM_ISA-1:0]  isa_irq,
  input logic                route_chg,
  input logic [NUM_PIRQ-1:0] route_en,
  input logic [IRQ_W-1:0]    route_irq
);

  // R5: no more ISA outputs active than enabled, asserted lines a cycle earlier
  p_isa_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(isa_irq) <= $countones($past(pirq_lvl & route_en)));

  // R4: with every line disabled, no ISA output is driven
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(route_en) == '0) |-> (isa_irq == '0));

  // R7: the notification only follows a write
  p_chg_after_wr_r7: assert property (@(posedge clk) disable iff (rst)
    route_chg |-> $past(cfg_wr));

  // R9: route status holds without a write
  p_route_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_wr) |-> ($stable(route_en) && $stable(route_irq)));

  // R11: read data holds without a read
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_rd) |-> $stable(cfg_rdata));

endmodule

bind pirq_router pirq_router_chk #(
  .NUM_PIRQ(NUM_PIRQ),
  .NUM_ISA (NUM_ISA),
  .DATA_W  (DATA_W),
  .IRQ_W   (NUM_PIRQ*$clog2(NUM_ISA))
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_wr   (cfg_wr),
  .cfg_rd   (cfg_rd),
  .cfg_rdata(cfg_rdata),
  .pirq_lvl (pirq_lvl),
  .isa_irq  (isa_irq),
  .route_chg(route_chg),
  .route_en (route_en),
  .route_irq(route_irq)
);

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;

  localparam int NP = 4;
  localparam int NI = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic [NP-1:0] pirq_lvl = '0;
  logic [NI-1:0] isa_irq;
  logic        route_chg;
  logic [NP-1:0] route_en;
  logic [NP*4-1:0] route_irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
    .cfg_rdata(cfg_rdata), .pirq_lvl(pirq_lvl), .isa_irq(isa_irq),
    .route_chg(route_chg), .route_en(route_en), .route_irq(route_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = b;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  function automatic logic [NI-1:0] expect_isa(input logic [7:0] r [NP], input logic [NP-1:0] l);
    logic [NI-1:0] e = '0;
    for (int n = 0; n < NP; n++)
      if (l[n] && r[n] < NI) e[r[n][3:0]] = 1'b1;
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  rt [NP];
    logic [NP-1:0] lv;
    logic [31:0] exp_dw;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 isa", 32'(isa_irq), 32'h0);
    check("R1 en", 32'(route_en), 32'h0);
    check("R1 chg", 32'(route_chg), 32'h0);
    check("R1 rdata", cfg_rdata, 32'h0);
    cfg_read(8'h60, rd); check("R1 route bytes", rd, 32'h80808080);

    // R2: fixed defaults
    cfg_read(8'h04, rd); check("R2 dword 0x04", rd, 32'h02000007);
    cfg_read(8'h4C, rd); check("R2 dword 0x4C", rd, 32'h0003004D);
    cfg_read(8'h68, rd); check("R2 dword 0x68", rd, 32'h00000200);
    cfg_read(8'h70, rd); check("R2 dword 0x70", rd, 32'h00000080);

    // R11: read data holds while idle
    repeat (2) @(negedge clk);
    check("R11 hold", cfg_rdata, 32'h00000080);

    // R10: unimplemented offsets
    cfg_read(8'h00, rd); check("R10 read 0x00", rd, 32'h0);
    cfg_write(8'h64, 32'hFFFFFFFF, 4'hF);
    check("R7 no pulse on 0x64", 32'(route_chg), 32'h0);
    cfg_read(8'h64, rd); check("R10 write ignored 0x64", rd, 32'h0);
    cfg_read(8'h60, rd); check("R10 routes untouched", rd, 32'h80808080);
    cfg_write(8'h04, 32'hAABBCC55, 4'h7);
    check("R7 no pulse on 0x04", 32'(route_chg), 32'h0);
    cfg_read(8'h04, rd); check("R2 R10 write 0x04", rd, 32'h02000055);
    cfg_read(8'hFC, rd); check("R10 read 0xFC", rd, 32'h0);

    // R3 R4 R6 R7 R9 R8: per-line sweep of route values
    for (int n = 0; n < NP; n++) begin
      for (int k = 0; k < 34; k++) begin
        logic [7:0] v;
        v = (k < 32) ? 8'(k) : ((k == 32) ? 8'h80 : 8'hFF);
        cfg_write(8'h60, {4{v}}, 4'(1 << n));
        check("R7 pulse", 32'(route_chg), 32'h1);
        check("R9 enable", 32'(route_en), (v < NI) ? 32'(1 << n) : 32'h0);
        check("R9 number", 32'(route_irq[n*4 +: 4]), 32'(v[3:0]));
        pirq_lvl = NP'(1 << n);
        @(negedge clk);
        check("R7 pulse one cycle", 32'(route_chg), 32'h0);
        check("R3 R4 isa", 32'(isa_irq), (v < NI) ? 32'(1 << v) : 32'h0);
        pirq_lvl = '0;
        @(negedge clk);
        check("R8 level drop", 32'(isa_irq), 32'h0);
        exp_dw = 32'h80808080;
        exp_dw[n*8 +: 8] = v;
        cfg_read(8'h60, rd); check("R6 lanes", rd, exp_dw);
      end
      cfg_write(8'h60, 32'h80808080, 4'hF);
    end

    // R6: explicit partial write
    cfg_write(8'h60, 32'h11223344, 4'b0101);
    cfg_read(8'h60, rd); check("R6 partial", rd, 32'h80228044);

    // R8: route write lag with all levels high
    cfg_write(8'h60, 32'h80808080, 4'hF);
    pirq_lvl = '1;
    @(negedge clk);
    check("R8 disabled", 32'(isa_irq), 32'h0);
    cfg_write(8'h60, 32'h80808005, 4'h1);
    check("R8 old route still", 32'(isa_irq), 32'h0);
    @(negedge clk);
    check("R8 new route", 32'(isa_irq), 32'h0020);
    pirq_lvl = '0;
    @(negedge clk);

    // R5: mixes of routes and levels, including shared targets
    for (int k = 0; k < 100; k++) begin
      for (int n = 0; n < NP; n++) rt[n] = 8'(((k * 7) + (n * 11) + 3) % 20);
      if (k % 5 == 0) begin rt[1] = rt[0]; rt[2] = rt[0]; end
      lv = NP'((k * 3) % 16);
      cfg_write(8'h60, {rt[3], rt[2], rt[1], rt[0]}, 4'hF);
      pirq_lvl = lv;
      @(negedge clk);
      check("R5 shared OR", 32'(isa_irq), 32'(expect_isa(rt, lv)));
      pirq_lvl = '0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule